// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one direction of a peripheral data mover. A serial peripheral pulses a request each time it has a data word ready, or has room for one. On each request the channel performs a single memory access at its current pointer. For the receive variant this is a write of the word the peripheral offered. For the transmit variant it is a read, and the returned word is handed back to the peripheral. After every completed access the pointer moves forward by the access size and the remaining count drops by one.

Software keeps two pointer/count pairs. The active pair drives the traffic. The queued pair stands ready behind it. When the active count runs out, a non-zero queued pair is moved into the active pair on the same clock edge, so the stream continues without a gap, and the queued pair is then zeroed. If nothing is queued, the channel halts and raises a "dry" flag, which means buffer full on receive and buffer empty on transmit. An end-of-buffer flag marks every exhaustion of the active pair.

The parameter `DIR` selects the direction: 0 for receive, 1 for transmit. The register port writes one of the four registers per cycle. All four registers are visible as outputs.

Top module: `dma_periph_chan`

## Requirements
- R1: While rst_ni is low, every pointer and count output, both flags, mem_req_o and per_valid_o are zero.
- R2: When en_i is high and the active count is non-zero, a request starts one memory access. mem_req_o rises on the cycle after the request is taken and carries the active pointer on mem_addr_o. It stays high, with address and data held, until the cycle in which mem_ack_i is high. Only one access is outstanding at a time.
- R3: The cycle in which mem_ack_i meets mem_req_o completes the access. The active pointer then advances by 1, 2 or 4 bytes for size_i = 0, 1 and 2 respectively; size_i = 3 also steps by 4. The active count drops by one.
- R4: In the receive variant, mem_we_o is 1 and mem_wdata_o is the per_data_i value that was sampled together with the request being served.
- R5: A request that arrives while an access is outstanding is held (one deep) and served as soon as the bus is free. A request that arrives while en_i is low, or while the active count is zero, is dropped.
- R6: When an access completes with an active count of 1 and a non-zero queued count, the queued pointer and count become the active pair on that edge. The queued pair then reads zero.
- R7: Every completion that empties the active pair sets end_buf_o. Writing a non-zero value to the active count (select 1) or to the queued count (select 3) clears it. When a set and a clear fall in the same cycle, the set wins.
- R8: A completion that empties the active pair while the queued count is zero sets buf_dry_o, leaves the active count at zero and stops further accesses. Only a non-zero write to the active count (select 1) clears buf_dry_o.
- R9: reg_sel_i chooses the register written: 0 active pointer, 1 active count, 2 queued pointer, 3 queued count. Count writes take the low 16 bits of reg_wdata_i. Writing the queued registers during an access leaves the active pair and the access itself untouched.
- R10: A register write in the same cycle as a completion gives the written register the written value. This includes a queued-count write on a reload edge, whose value survives instead of being cleared.
- R11: Writing zero to a count clears neither flag.
- R12: In the transmit variant, mem_we_o is 0. One cycle after the completing edge, per_valid_o pulses for one cycle with per_data_o equal to the mem_rdata_i value returned with the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (see R9) |
| reg_wdata_i | input | AW | Register write value |
| cur_ptr_o | output | AW | Active pointer |
| cur_cnt_o | output | CW | Active count |
| nxt_ptr_o | output | AW | Queued pointer |
| nxt_cnt_o | output | CW | Queued count |
| per_req_i | input | 1 | Peripheral request pulse |
| per_data_i | input | DW | Peripheral word (receive) |
| per_data_o | output | DW | Word returned to peripheral (transmit) |
| per_valid_o | output | 1 | per_data_o valid pulse (transmit) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the access |
| end_buf_o | output | 1 | End-of-buffer flag |
| buf_dry_o | output | 1 | Channel ran dry (full on receive, empty on transmit) |

## Verification
The bench targets the reload edge. A design that reloads one cycle late would issue an access at the stale pointer. A design that forgets to zero the queued pair would reload the same buffer twice. It also lands a queued-count write exactly on the reload edge, where a design with the wrong priority loses the software value. Requests are sent during a long access, and against a disabled or drained channel: a missing hold drops a word, and a missing gate writes past the end of the buffer. The bench also checks which writes clear which flag, including zero writes, where a loose compare would clear the dry flag early.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SEL_CUR_PTR = 2'd0,
    SEL_CUR_CNT = 2'd1,
    SEL_NXT_PTR = 2'd2,
    SEL_NXT_CNT = 2'd3
  } reg_sel_e;

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          done_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic [AW-1:0] nxt_ptr_o,
  output logic [CW-1:0] nxt_cnt_o,
  output logic          end_buf_o,
  output logic          buf_dry_o
);

  logic [AW-1:0] cur_ptr_q, nxt_ptr_q;
  logic [CW-1:0] cur_cnt_q, nxt_cnt_q;
  logic          end_q, dry_q;

  logic [CW-1:0] wcnt;
  logic          step_ok, last, reload, wr_cur_cnt, wr_nxt_cnt;

  assign wcnt       = wdata_i[CW-1:0];
  assign step_ok    = done_i && (cur_cnt_q != '0);
  assign last       = step_ok && (cur_cnt_q == CW'(1));
  assign reload     = last && (nxt_cnt_q != '0);
  assign wr_cur_cnt = we_i && (reg_sel_e'(sel_i) == SEL_CUR_CNT);
  assign wr_nxt_cnt = we_i && (reg_sel_e'(sel_i) == SEL_NXT_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ptr_q <= '0;
      cur_cnt_q <= '0;
      nxt_ptr_q <= '0;
      nxt_cnt_q <= '0;
    end else begin
      // software write overrides the hardware update of the same register
      if (we_i && reg_sel_e'(sel_i) == SEL_CUR_PTR) cur_ptr_q <= wdata_i;
      else if (reload)                              cur_ptr_q <= nxt_ptr_q;
      else if (step_ok)                             cur_ptr_q <= cur_ptr_q + AW'(step_bytes(size_i));

      if (wr_cur_cnt)   cur_cnt_q <= wcnt;
      else if (reload)  cur_cnt_q <= nxt_cnt_q;
      else if (step_ok) cur_cnt_q <= cur_cnt_q - CW'(1);

      if (we_i && reg_sel_e'(sel_i) == SEL_NXT_PTR) nxt_ptr_q <= wdata_i;
      else if (reload)                              nxt_ptr_q <= '0;

      if (wr_nxt_cnt)   nxt_cnt_q <= wcnt;
      else if (reload)  nxt_cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q <= 1'b0;
      dry_q <= 1'b0;
    end else begin
      if (last)                                      end_q <= 1'b1;
      else if ((wr_cur_cnt || wr_nxt_cnt) && wcnt != '0) end_q <= 1'b0;

      if (last && !reload)                           dry_q <= 1'b1;
      else if (wr_cur_cnt && wcnt != '0)             dry_q <= 1'b0;
    end
  end

  assign cur_ptr_o = cur_ptr_q;
  assign cur_cnt_o = cur_cnt_q;
  assign nxt_ptr_o = nxt_ptr_q;
  assign nxt_cnt_o = nxt_cnt_q;
  assign end_buf_o = end_q;
  assign buf_dry_o = dry_q;

endmodule

// File: rtl/dma_chan_xfer.sv
module dma_chan_xfer #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int DIR = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          per_req_i,
  input  logic [DW-1:0] per_data_i,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          done_o,
  output logic [DW-1:0] per_data_o,
  output logic          per_valid_o
);

  localparam logic IS_TX = (DIR != 0);

  logic          busy_q, pend_q, valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] hold_q, wdata_q, rdata_q;
  logic          launch, done;

  assign launch = !busy_q && active_i && (per_req_i || pend_q);
  assign done   = busy_q && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      hold_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (launch)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      // one-deep request memory, dropped whenever the channel is inactive
      pend_q <= active_i && !launch && (pend_q || per_req_i);
      if (per_req_i) hold_q <= per_data_i;
      if (launch) begin
        addr_q  <= cur_ptr_i;
        wdata_q <= per_req_i ? per_data_i : hold_q;
      end
      if (done) rdata_q <= mem_rdata_i;
      valid_q <= done;
    end
  end

  assign mem_req_o   = busy_q;
  assign mem_we_o    = !IS_TX;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done;
  assign per_data_o  = rdata_q;
  assign per_valid_o = valid_q && IS_TX;

endmodule

// File: rtl/dma_periph_chan.sv
module dma_periph_chan #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DW  = 32,
  parameter int DIR = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    size_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic [AW-1:0] nxt_ptr_o,
  output logic [CW-1:0] nxt_cnt_o,
  input  logic          per_req_i,
  input  logic [DW-1:0] per_data_i,
  output logic [DW-1:0] per_data_o,
  output logic          per_valid_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          end_buf_o,
  output logic          buf_dry_o
);

  logic done, active;

  assign active = en_i && (cur_cnt_o != '0);

  dma_chan_regs #(.AW(AW), .CW(CW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (done),
    .size_i    (size_i),
    .cur_ptr_o (cur_ptr_o),
    .cur_cnt_o (cur_cnt_o),
    .nxt_ptr_o (nxt_ptr_o),
    .nxt_cnt_o (nxt_cnt_o),
    .end_buf_o (end_buf_o),
    .buf_dry_o (buf_dry_o)
  );

  dma_chan_xfer #(.AW(AW), .DW(DW), .DIR(DIR)) i_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .per_req_i   (per_req_i),
    .per_data_i  (per_data_i),
    .cur_ptr_i   (cur_ptr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done),
    .per_data_o  (per_data_o),
    .per_valid_o (per_valid_o)
  );

endmodule

// File: rtl/dma_periph_chan_chk.sv
module dma_periph_chan_chk
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [1:0]    size_i,
  input logic          reg_we_i,
  input logic [AW-1:0] cur_ptr_o,
  input logic [CW-1:0] cur_cnt_o,
  input logic [CW-1:0] nxt_cnt_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          end_buf_o,
  input logic          buf_dry_o
);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && cur_cnt_o > CW'(1) && !reg_we_i |=>
      cur_cnt_o == $past(cur_cnt_o) - CW'(1) &&
      cur_ptr_o == $past(cur_ptr_o) + AW'(step_bytes($past(size_i))));

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(mem_req_o));

  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && cur_cnt_o == CW'(1) && nxt_cnt_o != '0 && !reg_we_i |=>
      cur_cnt_o == $past(nxt_cnt_o) && nxt_cnt_o == '0 && end_buf_o);

  p_dry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && cur_cnt_o == CW'(1) && nxt_cnt_o == '0 && !reg_we_i |=>
      buf_dry_o && end_buf_o && cur_cnt_o == '0);

endmodule

bind dma_periph_chan dma_periph_chan_chk #(.AW(AW), .CW(CW), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .size_i      (size_i),
  .reg_we_i    (reg_we_i),
  .cur_ptr_o   (cur_ptr_o),
  .cur_cnt_o   (cur_cnt_o),
  .nxt_cnt_o   (nxt_cnt_o),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .end_buf_o   (end_buf_o),
  .buf_dry_o   (buf_dry_o)
);

// File: tb/test_dma_periph_chan.sv
`timescale 1ns/1ps
module test_dma_periph_chan;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        en = 0, tx_en = 0, reg_we = 0, per_req = 0, mem_ack = 0, tx_ack = 0;
  logic [1:0]  size = 0, sel = 0;
  logic [31:0] wdata = 0, per_data = 0, tx_rdata = 0;
  logic [31:0] cur_ptr, nxt_ptr, per_data_o, mem_addr, mem_wdata;
  logic [15:0] cur_cnt, nxt_cnt;
  logic        per_valid, mem_req, mem_we, eob, dry;
  logic [31:0] t_cur_ptr, t_nxt_ptr, t_per_data, t_addr, t_wdata;
  logic [15:0] t_cur_cnt, t_nxt_cnt;
  logic        t_valid, t_req, t_we, t_eob, t_dry;

  dma_periph_chan i_dma_periph_chan (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .size_i(size),
    .reg_we_i(reg_we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .cur_ptr_o(cur_ptr), .cur_cnt_o(cur_cnt), .nxt_ptr_o(nxt_ptr), .nxt_cnt_o(nxt_cnt),
    .per_req_i(per_req), .per_data_i(per_data), .per_data_o(per_data_o), .per_valid_o(per_valid),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(32'h0), .mem_ack_i(mem_ack), .end_buf_o(eob), .buf_dry_o(dry));

  dma_periph_chan #(.DIR(1)) i_tx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(tx_en), .size_i(size),
    .reg_we_i(reg_we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .cur_ptr_o(t_cur_ptr), .cur_cnt_o(t_cur_cnt), .nxt_ptr_o(t_nxt_ptr), .nxt_cnt_o(t_nxt_cnt),
    .per_req_i(per_req), .per_data_i(per_data), .per_data_o(t_per_data), .per_valid_o(t_valid),
    .mem_req_o(t_req), .mem_we_o(t_we), .mem_addr_o(t_addr), .mem_wdata_o(t_wdata),
    .mem_rdata_i(tx_rdata), .mem_ack_i(tx_ack), .end_buf_o(t_eob), .buf_dry_o(t_dry));

  int total = 0, bad = 0, lat = 1, wait_c = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference of the receive channel
  logic [31:0] m_cptr, m_nptr, m_addr, m_wd, m_hold;
  logic [15:0] m_ccnt, m_ncnt;
  logic        m_eob, m_dry, m_busy, m_pend;
  logic [31:0] n_cptr, n_nptr;
  logic [15:0] n_ccnt, n_ncnt;
  logic        act_v, launch_v, done_v, end_v, rel_v, n_eob, n_dry;
  int          stp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cptr = 0; m_nptr = 0; m_ccnt = 0; m_ncnt = 0; m_eob = 0; m_dry = 0;
      m_busy = 0; m_pend = 0; m_addr = 0; m_wd = 0; m_hold = 0;
    end else begin
      act_v    = en && (m_ccnt != 0);
      launch_v = !m_busy && act_v && (per_req || m_pend);
      done_v   = m_busy && mem_ack;
      end_v    = done_v && (m_ccnt == 1);
      rel_v    = end_v && (m_ncnt != 0);
      stp      = (size == 0) ? 1 : (size == 1) ? 2 : 4;
      n_cptr = m_cptr; n_ccnt = m_ccnt; n_nptr = m_nptr; n_ncnt = m_ncnt;
      if (done_v && m_ccnt != 0) begin
        if (rel_v) begin n_cptr = m_nptr; n_ccnt = m_ncnt; n_nptr = 0; n_ncnt = 0; end
        else begin n_cptr = m_cptr + stp; n_ccnt = m_ccnt - 1; end
      end
      if (reg_we) begin
        if (sel == 0) n_cptr = wdata;
        if (sel == 1) n_ccnt = wdata[15:0];
        if (sel == 2) n_nptr = wdata;
        if (sel == 3) n_ncnt = wdata[15:0];
      end
      n_eob = end_v || (m_eob && !(reg_we && (sel == 1 || sel == 3) && wdata[15:0] != 0));
      n_dry = (end_v && m_ncnt == 0) || (m_dry && !(reg_we && sel == 1 && wdata[15:0] != 0));
      if (launch_v) begin
        m_addr = m_cptr;
        m_wd   = per_req ? per_data : m_hold;
      end
      if (per_req) m_hold = per_data;
      m_pend = act_v && !launch_v && (m_pend || per_req);
      m_busy = launch_v ? 1'b1 : (done_v ? 1'b0 : m_busy);
      m_cptr = n_cptr; m_ccnt = n_ccnt; m_nptr = n_nptr; m_ncnt = n_ncnt;
      m_eob = n_eob; m_dry = n_dry;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 cur_ptr", cur_ptr, m_cptr);
      chk("R3 cur_cnt", cur_cnt, m_ccnt);
      chk("R6 nxt_ptr", nxt_ptr, m_nptr);
      chk("R6 nxt_cnt", nxt_cnt, m_ncnt);
      chk("R7 end_buf", eob, m_eob);
      chk("R8 buf_dry", dry, m_dry);
      chk("R2 mem_req", mem_req, m_busy);
      if (mem_req) begin
        chk("R2 mem_addr", mem_addr, m_addr);
        chk("R4 mem_wdata", mem_wdata, m_wd);
        chk("R4 mem_we", mem_we, 1'b1);
      end
    end
  end

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wait_c >= lat) mem_ack = 1'b1;
      else wait_c++;
    end else begin
      mem_ack = 1'b0;
      wait_c  = 0;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    reg_we = 1; sel = s; wdata = v; tick(); reg_we = 0;
  endtask
  task automatic preq(input logic [31:0] d);
    per_req = 1; per_data = d; tick(); per_req = 0;
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 rst cur_ptr", cur_ptr, 0);
    chk("R1 rst cur_cnt", cur_cnt, 0);
    chk("R1 rst nxt", {nxt_ptr, 16'h0, nxt_cnt}, 0);
    chk("R1 rst flags", {eob, dry, mem_req, t_valid}, 0);
    rst_n = 1;
    tick();

    // reload then run dry, word size
    size = 2; lat = 1;
    wr(0, 32'h1000); wr(3, 2); wr(2, 32'h2000); wr(1, 3);
    en = 1;
    for (int i = 0; i < 3; i++) begin preq(32'hA000 + i); repeat (4) tick(); end
    chk("R6 reload ptr", cur_ptr, 32'h2000);
    chk("R6 reload cnt", cur_cnt, 2);
    chk("R6 nxt cleared", {nxt_ptr, nxt_cnt}, 0);
    chk("R7 end set on reload", eob, 1);
    chk("R8 no dry on reload", dry, 0);
    for (int i = 0; i < 2; i++) begin preq(32'hB000 + i); repeat (4) tick(); end
    chk("R3 final ptr", cur_ptr, 32'h2008);
    chk("R8 dry set", dry, 1);
    chk("R8 cnt zero", cur_cnt, 0);
    preq(32'hDEAD);
    tick();
    chk("R8 stopped no req", mem_req, 0);
    repeat (2) tick();

    // flag clearing rules
    wr(1, 0);
    chk("R11 zero write keeps dry", dry, 1);
    chk("R11 zero write keeps end", eob, 1);
    wr(3, 0);
    chk("R11 zero nxt keeps end", eob, 1);
    wr(0, 32'h3000); wr(2, 32'h0);
    wr(1, 32'h0001_0002);
    chk("R9 count takes low bits", cur_cnt, 2);
    chk("R8 dry cleared", dry, 0);
    chk("R7 end cleared", eob, 0);

    // pending request during a long access, halfword
    size = 1; lat = 3;
    preq(32'h1111_1111);
    tick();
    preq(32'h2222_2222);
    repeat (14) tick();
    chk("R5 both served ptr", cur_ptr, 32'h3004);
    chk("R5 both served dry", dry, 1);

    // disabled channel drops requests
    en = 0;
    wr(1, 3);
    preq(32'h3333);
    repeat (3) tick();
    chk("R5 disabled no req", mem_req, 0);
    chk("R5 disabled cnt", cur_cnt, 3);

    // write on reload edge, byte size
    en = 1; size = 0; lat = 0;
    wr(0, 32'h4000); wr(1, 1); wr(2, 32'h5000); wr(3, 4);
    chk("R7 end cleared by nxt", eob, 0);
    preq(32'h4444);
    wr(3, 7);
    chk("R10 reload ptr", cur_ptr, 32'h5000);
    chk("R10 reload cnt", cur_cnt, 4);
    chk("R10 nxt write survives", nxt_cnt, 7);
    chk("R10 end set wins", eob, 1);
    tick();

    // queued write during an access
    lat = 2;
    preq(32'h5555);
    wr(2, 32'h6000);
    repeat (5) tick();
    chk("R9 ptr byte step", cur_ptr, 32'h5001);
    chk("R9 cnt", cur_cnt, 3);
    chk("R9 nxt ptr", nxt_ptr, 32'h6000);
    size = 3;
    preq(32'h6666); repeat (6) tick();
    chk("R3 size3 step", cur_ptr, 32'h5005);
    size = 1;
    preq(32'h7777); repeat (6) tick();
    chk("R3 size1 step", cur_ptr, 32'h5007);
    chk("R3 cnt after steps", cur_cnt, 1);
    en = 0;
    tick();

    // transmit variant
    size = 2;
    wr(3, 0); wr(0, 32'h40); wr(1, 1);
    tx_en = 1;
    preq(32'h0);
    chk("R12 tx req", t_req, 1);
    chk("R12 tx read", t_we, 0);
    chk("R12 tx addr", t_addr, 32'h40);
    tx_ack = 1; tx_rdata = 32'hCAFE_F00D;
    tick();
    tx_ack = 0;
    chk("R12 tx valid", t_valid, 1);
    chk("R12 tx data", t_per_data, 32'hCAFE_F00D);
    chk("R8 tx empty flag", t_dry, 1);
    tick();
    chk("R12 tx valid pulse", t_valid, 0);
    chk("R2 tx idle", t_req, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule